// File: doc/BRIEF.md
# Storage Tube Cycle Timing Sequencer

This block times each access of a word-parallel electrostatic storage array with 45 bit lanes. A start request opens a fixed 48-tick cycle, with one tick of 0.25 µs. First comes a quiet period while the beam deflection settles. Then the block opens the grid gate of every lane and raises a ramp enable for the Y deflection. It raises a one-tick read strobe, during which each lane's sense output is sampled. Each lane then either closes its gate after the short base pulse, which stores a zero as a dot, or holds it open for the long pulse, which stores a one as a dash.

On a read or refresh access, the sampled sense bit picks the pulse length. Every access therefore rewrites what it reads, and the sampled word is returned on the read-data port. On a write access, the write data captured with the start request picks the pulse length, and the read-data port keeps its previous value. A done pulse marks the last tick. A start request seen during that tick opens the next cycle with no gap, so a stream of refresh accesses runs at one cycle every 48 ticks.

Top module: `tube_cycle_seq`

## Requirements
- R1: While reset is asserted, every grid gate, the strobe, the ramp enable and done are low, and read data is zero. This also holds when reset arrives in the middle of a cycle.
- R2: A start request accepted while idle begins a cycle at that clock edge, which is tick 0. During ticks 0 to 11 every grid gate and the ramp enable stay low.
- R3: During ticks 12 and 13 every lane's grid gate is high. The strobe is high during tick 13 only.
- R4: The ramp enable is high during ticks 12 through 21 and low during every other tick.
- R5: During ticks 14 through 21, lane i's grid gate is high exactly when its stretch bit is 1, and it is low from tick 22 on. The stretch bit is write-data bit i on a write, and sense bit i as sampled during tick 13 on a read.
- R6: After a read cycle, read-data bit i equals the value that sense bit i had during tick 13. Sense values in any other tick have no effect on read data.
- R7: The write flag and the write data are captured with the accepted start. Changes to them later in the cycle have no effect. A write cycle leaves read data unchanged.
- R8: Done is high during tick 47 only, and a cycle lasts exactly 48 ticks.
- R9: A start request during ticks 0 to 46 of a cycle is ignored. It neither restarts nor extends the cycle.
- R10: A start request present during tick 47 begins the next cycle at the following edge, so back-to-back cycles repeat every 48 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one period per 0.25 µs |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an access cycle |
| wr_en | input | 1 | 1 = write access, 0 = read or refresh access |
| wr_data | input | 45 | Word to store on a write access |
| sense | input | 45 | Per-lane sense amplifier outputs |
| grid_gate | output | 45 | Per-lane grid pulse gate |
| strobe | output | 1 | Read strobe, one tick |
| ramp_en | output | 1 | Enables the ramp added to the Y deflection |
| rd_data | output | 45 | Word sampled by the latest read cycle |
| done | output | 1 | High during the last tick of a cycle |

## Verification
The assertions assume that start, wr_en, wr_data and sense change only away from the active clock edge, and that reset is released at least one tick before a start request. The bench drives every input on the falling edge and releases reset several ticks before the first request. The bench holds sense at the inverse of the intended word during every tick except the strobe tick, and it scrambles the write flag and write data right after each start is accepted. A sequencer that samples either of them at the wrong time therefore produces a visibly wrong word. Stray start pulses land only inside running cycles or on the final tick, which are the only places where R9 and R10 give them a defined meaning.

// File: rtl/tube_seq_pkg.sv
package tube_seq_pkg;

  // Where the tick counter sits within one access cycle.
  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_BASE   = 2'd1,
    PH_TAIL   = 2'd2,
    PH_REST   = 2'd3
  } phase_t;

  // Map a tick number to a phase, given the window lengths.
  function automatic phase_t phase_at(input int unsigned tick,
                                      input int unsigned settle_len,
                                      input int unsigned base_len,
                                      input int unsigned long_len);
    if (tick < settle_len)                 return PH_SETTLE;
    else if (tick < settle_len + base_len) return PH_BASE;
    else if (tick < settle_len + long_len) return PH_TAIL;
    else                                   return PH_REST;
  endfunction

  // Gate rule for one lane: always open in the base window,
  // open in the tail window only for a dash.
  function automatic logic lane_open(input phase_t ph, input logic dash);
    return (ph == PH_BASE) || ((ph == PH_TAIL) && dash);
  endfunction

endpackage

// File: rtl/tube_seq_timer.sv
module tube_seq_timer
  import tube_seq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 12,
  parameter int unsigned BASE_TICKS   = 2,
  parameter int unsigned LONG_TICKS   = 10,
  parameter int unsigned CYCLE_TICKS  = 48,
  parameter int unsigned STROBE_POS   = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output logic   launch,
  output phase_t phase,
  output logic   strobe,
  output logic   ramp_en,
  output logic   last_tick
);
  localparam int unsigned CW          = $clog2(CYCLE_TICKS);
  localparam int unsigned STROBE_TICK = SETTLE_TICKS + STROBE_POS;
  localparam int unsigned FINAL_TICK  = CYCLE_TICKS - 1;

  logic          busy_q;
  logic [CW-1:0] tick_q;

  assign last_tick = busy_q && (tick_q == CW'(FINAL_TICK));
  // Accept when idle, or on the final tick so that cycles chain.
  assign launch    = start && (!busy_q || last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      tick_q <= '0;
    end else if (busy_q) begin
      if (last_tick) begin
        busy_q <= 1'b0;
        tick_q <= '0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign phase   = busy_q ? phase_at(32'(tick_q), SETTLE_TICKS, BASE_TICKS, LONG_TICKS)
                          : PH_REST;
  assign strobe  = busy_q && (tick_q == CW'(STROBE_TICK));
  assign ramp_en = (phase == PH_BASE) || (phase == PH_TAIL);

endmodule

// File: rtl/tube_seq_lane.sv
module tube_seq_lane
  import tube_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   launch,
  input  logic   launch_write,
  input  logic   wbit,
  input  logic   cycle_write,
  input  logic   strobe,
  input  logic   sense,
  input  phase_t phase,
  output logic   gate,
  output logic   rbit
);
  logic dash_q;
  logic rbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dash_q <= 1'b0;
      rbit_q <= 1'b0;
    end else if (launch) begin
      // Write cycles know their pulse length up front.
      dash_q <= launch_write && wbit;
    end else if (strobe && !cycle_write) begin
      // Read cycles regenerate whatever was sensed.
      dash_q <= sense;
      rbit_q <= sense;
    end
  end

  assign gate = lane_open(phase, dash_q);
  assign rbit = rbit_q;

endmodule

// File: rtl/tube_cycle_seq.sv
module tube_cycle_seq
  import tube_seq_pkg::*;
#(
  parameter int unsigned LANES        = 45,
  parameter int unsigned SETTLE_TICKS = 12,
  parameter int unsigned BASE_TICKS   = 2,
  parameter int unsigned LONG_TICKS   = 10,
  parameter int unsigned CYCLE_TICKS  = 48,
  parameter int unsigned STROBE_POS   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_data,
  input  logic [LANES-1:0] sense,
  output logic [LANES-1:0] grid_gate,
  output logic             strobe,
  output logic             ramp_en,
  output logic [LANES-1:0] rd_data,
  output logic             done
);
  // Named internal events, also observed by the checker.
  logic   launch_w;
  logic   cyc_write_q;
  phase_t phase_w;

  tube_seq_timer #(
    .SETTLE_TICKS(SETTLE_TICKS),
    .BASE_TICKS  (BASE_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .CYCLE_TICKS (CYCLE_TICKS),
    .STROBE_POS  (STROBE_POS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .launch   (launch_w),
    .phase    (phase_w),
    .strobe   (strobe),
    .ramp_en  (ramp_en),
    .last_tick(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc_write_q <= 1'b0;
    else if (launch_w) cyc_write_q <= wr_en;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tube_seq_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch_w),
      .launch_write(wr_en),
      .wbit        (wr_data[g]),
      .cycle_write (cyc_write_q),
      .strobe      (strobe),
      .sense       (sense[g]),
      .phase       (phase_w),
      .gate        (grid_gate[g]),
      .rbit        (rd_data[g])
    );
  end

endmodule

// File: rtl/tube_cycle_seq_checks.sv
module tube_cycle_seq_checks #(
  parameter int unsigned LANES = 45
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] grid_gate,
  input logic             strobe,
  input logic             ramp_en,
  input logic [LANES-1:0] rd_data,
  input logic             done,
  input logic             launch_w,
  input logic             cyc_write_q
);
  // R3: every lane is open while the strobe samples
  a_r3_strobe_all_open: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (&grid_gate));

  // R3: strobe lasts one tick
  a_r3_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R4: no lane is open outside the ramp window
  a_r4_gate_within_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (|grid_gate) |-> ramp_en);

  // R2: the tick after a launch is a settle tick
  a_r2_settle_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |=> (!ramp_en && (grid_gate == '0)));

  // R8: done lasts one tick and never meets the strobe
  a_r8_done_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_apart_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strobe);

  // R6: read data moves only right after a strobe
  a_r6_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(rd_data));

  // R7: a write cycle's strobe leaves read data alone
  a_r7_write_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cyc_write_q) |=> $stable(rd_data));

endmodule

bind tube_cycle_seq tube_cycle_seq_checks #(.LANES(LANES)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .grid_gate  (grid_gate),
  .strobe     (strobe),
  .ramp_en    (ramp_en),
  .rd_data    (rd_data),
  .done       (done),
  .launch_w   (launch_w),
  .cyc_write_q(cyc_write_q)
);

// File: tb/tube_cycle_seq_test.sv
`timescale 1ns/1ps
module tube_cycle_seq_test;
  localparam int L       = 45;
  localparam int PERIOD  = 250;
  localparam int CYC     = 48;
  localparam int OPEN_T  = 12;
  localparam int STB_T   = 13;
  localparam int TAIL_T  = 21;
  localparam logic [L-1:0] ONES = {L{1'b1}};

  typedef struct packed {
    logic         wr;
    logic [L-1:0] wd;
    logic [L-1:0] sv;
    logic [L-1:0] exp_rd;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{wr:1'b0, wd:45'h0,              sv:45'h1FFF_FFFF_FFFF, exp_rd:45'h1FFF_FFFF_FFFF},
    '{wr:1'b1, wd:45'h0AAA_AAAA_AAAA, sv:45'h0F0F_0F0F_0F0F, exp_rd:45'h1FFF_FFFF_FFFF},
    '{wr:1'b0, wd:45'h1FFF_FFFF_FFFF, sv:45'h1555_5555_5555, exp_rd:45'h1555_5555_5555},
    '{wr:1'b0, wd:45'h0,              sv:45'h0,              exp_rd:45'h0},
    '{wr:1'b1, wd:45'h1FFF_FFFF_FFFF, sv:45'h1234_5678_9ABC, exp_rd:45'h0},
    '{wr:1'b0, wd:45'h0,              sv:45'h1234_5678_9ABC, exp_rd:45'h1234_5678_9ABC},
    '{wr:1'b1, wd:45'h0,              sv:45'h1FFF_FFFF_FFFF, exp_rd:45'h1234_5678_9ABC}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         wr_en = 1'b0;
  logic [L-1:0] wr_data = '0;
  logic [L-1:0] sense = '0;
  logic [L-1:0] grid_gate;
  logic         strobe;
  logic         ramp_en;
  logic [L-1:0] rd_data;
  logic         done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tube_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
    .wr_data(wr_data), .sense(sense), .grid_gate(grid_gate),
    .strobe(strobe), .ramp_en(ramp_en), .rd_data(rd_data), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [L-1:0] act, input logic [L-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Expected gate word for tick t of a cycle with the given dash pattern.
  function automatic logic [L-1:0] want_gate(input int t, input logic [L-1:0] dash);
    if (t == OPEN_T || t == STB_T)  return ONES;
    if (t > STB_T && t <= TAIL_T)   return dash;
    return '0;
  endfunction

  // One access cycle; poke_t >= 1 drops a stray start into that tick.
  task automatic run_cycle(input logic wr, input logic [L-1:0] wd,
                           input logic [L-1:0] sv, input logic [L-1:0] exp_rd,
                           input int poke_t);
    logic [L-1:0] dash;
    int e_gate, e_stb, e_ramp, e_done, e_settle;
    logic [L-1:0] g_act, g_exp;
    dash = wr ? wd : sv;
    e_gate = 0; e_stb = 0; e_ramp = 0; e_done = 0; e_settle = 0;
    g_act = '0; g_exp = '0;
    @(negedge clk);
    start = 1'b1; wr_en = wr; wr_data = wd; sense = ~sv;
    @(posedge clk);
    for (int t = 0; t < CYC; t++) begin
      @(negedge clk);
      if (t == 0) begin wr_en = ~wr; wr_data = ~wd; end
      start = (t == poke_t);
      sense = (t == STB_T) ? sv : ~sv;
      if (grid_gate !== want_gate(t, dash)) begin
        if (e_gate == 0) begin g_act = grid_gate; g_exp = want_gate(t, dash); end
        e_gate++;
        if (t < OPEN_T) e_settle++;
      end
      if (strobe !== (t == STB_T)) e_stb++;
      if (ramp_en !== (t >= OPEN_T && t <= TAIL_T)) e_ramp++;
      if (done !== (t == CYC-1)) e_done++;
    end
    check(e_settle == 0, "R2", "gate open during settle", L'(e_settle), '0);
    check(e_gate == 0, "R5", "grid gate pattern", g_act, g_exp);
    check(e_stb == 0, "R3", "strobe tick", L'(e_stb), '0);
    check(e_ramp == 0, "R4", "ramp window", L'(e_ramp), '0);
    check(e_done == 0, "R8", "done tick", L'(e_done), '0);
    @(negedge clk);
    start = 1'b0;
    check(rd_data === exp_rd, wr ? "R7" : "R6", "read data", rd_data, exp_rd);
    check(done === 1'b0 && grid_gate === '0, "R9", "idle after cycle",
          {grid_gate[L-2:0], done}, '0);
    for (int k = 0; k < OPEN_T; k++) @(negedge clk);
    check(grid_gate === '0 && ramp_en === 1'b0, "R9", "no hidden cycle",
          grid_gate, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    check(grid_gate === '0, "R1", "grid under reset", grid_gate, '0);
    check({strobe, ramp_en, done} === 3'b000, "R1", "controls under reset",
          L'({strobe, ramp_en, done}), '0);
    check(rd_data === '0, "R1", "read data under reset", rd_data, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VECS[i])
      run_cycle(VECS[i].wr, VECS[i].wd, VECS[i].sv, VECS[i].exp_rd, -1);

    // R9: stray starts inside a read and a write cycle
    run_cycle(1'b0, '0, 45'h0C3C_3C3C_3C3C, 45'h0C3C_3C3C_3C3C, 20);
    run_cycle(1'b1, 45'h1F00_00FF_0F0F, 45'h0, 45'h0C3C_3C3C_3C3C, 46);

    // R10: start held high gives back-to-back cycles
    begin
      int e_b2b;
      e_b2b = 0;
      @(negedge clk);
      start = 1'b1; wr_en = 1'b0; sense = 45'h0AAA_0000_5555;
      @(posedge clk);
      for (int t = 0; t < 2*CYC; t++) begin
        @(negedge clk);
        if (t == 2*CYC-1) start = 1'b0;
        if (done !== (t == CYC-1 || t == 2*CYC-1)) e_b2b++;
        if (t == CYC + OPEN_T && grid_gate !== ONES) e_b2b++;
        if (t == CYC && grid_gate !== '0) e_b2b++;
      end
      check(e_b2b == 0, "R10", "chained cycles", L'(e_b2b), '0);
      @(negedge clk);
      check(done === 1'b0 && ramp_en === 1'b0, "R10", "stops when start drops",
            L'({done, ramp_en}), '0);
      check(rd_data === 45'h0AAA_0000_5555, "R6", "read data after chain",
            rd_data, 45'h0AAA_0000_5555);
    end

    // R1: reset in the middle of a cycle
    @(negedge clk);
    start = 1'b1; wr_en = 1'b0; sense = ONES;
    @(posedge clk);
    for (int t = 0; t < STB_T; t++) @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(grid_gate === '0 && {strobe, ramp_en, done} === 3'b000, "R1",
          "mid-cycle reset", grid_gate, '0);
    check(rd_data === '0, "R1", "read data cleared", rd_data, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule